// File: doc/BRIEF.md
# Countdown Delay and Sound Timers

This block holds the two 8-bit countdown timers of a small retro virtual-machine core. One is a delay timer that software polls to pace itself. The other is a sound timer whose nonzero state switches an external buzzer on. Each timer has its own write strobe, which copies a shared data byte into it. Both timer values appear on read ports, so the CPU can copy the delay value into a register.

The block divides the system clock to produce a one-cycle tick at a fixed rate, 60 Hz by default. The two timers share this tick. On each tick, every nonzero timer drops by one. A timer at zero stays at zero and never wraps. A write on the same edge as a tick takes priority over the decrement. A synchronous reset clears both timers and restarts the divider from the start of its period.

Top module: `vm_timers`

## Requirements
- R1: While `rst` is high at a clock edge, both timers become 0, `buzz_on` becomes 0 and the divider restarts. Counting the first edge with `rst` low as edge 1, the divider phase is measured from that edge.
- R2: With DIV = CLK_HZ / TICK_HZ (at least 1), a nonzero timer that is not written decrements by exactly one on edges DIV, 2·DIV, 3·DIV, … after reset release. It holds its value on every other edge.
- R3: A timer at value 0 that is not written stays at 0 on every edge, ticks included. It never wraps to 255.
- R4: When `dly_wr` (or `snd_wr`) is high at an edge, that timer holds `wr_data` after that edge, and its read port (`dly_val` or `snd_val`) shows the value.
- R5: A write on an edge that is also a tick edge loads `wr_data` unchanged. The write wins over the decrement.
- R6: The timers are independent. A strobe changes only its own timer. With both strobes high, both timers load `wr_data`.
- R7: `buzz_on` is 1 in every cycle in which the sound timer is nonzero, and 0 whenever it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dly_wr | input | 1 | Write strobe for the delay timer |
| snd_wr | input | 1 | Write strobe for the sound timer |
| wr_data | input | W | Value loaded by either strobe |
| dly_val | output | W | Current delay timer value |
| snd_val | output | W | Current sound timer value |
| buzz_on | output | 1 | Buzzer enable, high while the sound timer is nonzero |

## Verification
Every result is registered.

- **Writes (R4):** a write shows on its read port after the single edge that samples the strobe.
- **Decrements (R2):** a decrement appears after edge k·DIV, counted from reset release.
- **Buzzer (R7):** `buzz_on` changes in the same cycle as the sound timer value.

The bench keeps its own edge counter from reset release. It drives inputs after the falling edge and samples every output at the next falling edge, so each value is compared half a period after the edge that produced it. It runs the small configuration DIV = 7. It sweeps the write phase across the whole divider period and compares both timers and the buzzer on every cycle against an expected value derived arithmetically from the edge count.

// File: rtl/vm_timers_pkg.sv
package vm_timers_pkg;

  localparam int unsigned NUM_TIMERS = 2;
  localparam int unsigned IDX_DLY    = 0;
  localparam int unsigned IDX_SND    = 1;

  function automatic int unsigned calc_div(input int unsigned clk_hz,
                                           input int unsigned tick_hz);
    int unsigned d;
    d = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/vmt_tick_gen.sv
module vmt_tick_gen #(
  parameter int unsigned DIV = 833333
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV == 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end

      assign tick = (cnt == LAST);

      // R2: a tick never lasts two cycles
      p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
      // R1: the divider restarts from the start of its period
      p_restart_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0));
    end
  endgenerate

endmodule

// File: rtl/vmt_countdown.sv
module vmt_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] value,
  output logic         nonzero
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = value;
    if (ld) begin
      nxt = ld_data;
    end else if (tick && (value != '0)) begin
      nxt = value - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= '0;
      nonzero <= 1'b0;
    end else begin
      value   <= nxt;
      nonzero <= (nxt != '0);
    end
  end

  // R4/R5: a load always takes the written value
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld |=> (value == $past(ld_data)));
  // R3: a zero count that is not written stays at zero
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && value == '0) |=> (value == '0));
  // R2: without a load the value only holds or drops by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (value == $past(value) || value == $past(value) - W'(1)));
  // R7: nonzero flag tracks the count
  p_flag_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (nonzero == (value != '0)));

endmodule

// File: rtl/vm_timers.sv
module vm_timers
  import vm_timers_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50000000,
  parameter int unsigned TICK_HZ = 60,
  parameter int unsigned W       = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dly_wr,
  input  logic         snd_wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dly_val,
  output logic [W-1:0] snd_val,
  output logic         buzz_on
);
  localparam int unsigned DIV = calc_div(CLK_HZ, TICK_HZ);

  logic                  tick;
  logic [NUM_TIMERS-1:0] wr_vec;
  logic [NUM_TIMERS-1:0] nz_vec;
  logic [W-1:0]          val_arr [NUM_TIMERS];

  assign wr_vec[IDX_DLY] = dly_wr;
  assign wr_vec[IDX_SND] = snd_wr;

  vmt_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      vmt_countdown #(.W(W)) u_cd (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ld      (wr_vec[t]),
        .ld_data (wr_data),
        .value   (val_arr[t]),
        .nonzero (nz_vec[t])
      );
    end
  endgenerate

  assign dly_val = val_arr[IDX_DLY];
  assign snd_val = val_arr[IDX_SND];
  assign buzz_on = nz_vec[IDX_SND];

  // R7: buzzer follows the sound count
  p_buzz_r7: assert property (@(posedge clk) disable iff (rst)
    buzz_on == (snd_val != '0));
  // R6: a sound-only write leaves the delay timer unmoved or ticking
  p_indep_r6: assert property (@(posedge clk) disable iff (rst)
    (snd_wr && !dly_wr && !tick) |=> $stable(dly_val));
  // R1: reset clears both timers and the buzzer
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (dly_val == '0 && snd_val == '0 && !buzz_on));

endmodule

// File: tb/sim_vm_timers.sv
module sim_vm_timers;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 700;
  localparam int TICK_HZ = 100;
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dly_wr = 1'b0;
  logic       snd_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] dly_val, snd_val;
  logic       buzz_on;

  int total = 0;
  int bad = 0;
  int n = 0;
  int exp_d = 0;
  int exp_s = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_timers #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .W(8)) u0 (
    .clk(clk), .rst(rst), .dly_wr(dly_wr), .snd_wr(snd_wr),
    .wr_data(wr_data), .dly_val(dly_val), .snd_val(snd_val),
    .buzz_on(buzz_on)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, act, exp, n);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 R3 delay"}, int'(dly_val), exp_d);
    check({tag, " R2 R3 sound"}, int'(snd_val), exp_s);
    check({tag, " R7 buzzer"}, int'(buzz_on), (exp_s != 0) ? 1 : 0);
  endtask

  // called just after a falling edge; applies inputs for one rising edge
  task automatic cyc(input logic wd, input logic ws, input int data);
    dly_wr  = wd;
    snd_wr  = ws;
    wr_data = 8'(data);
    @(posedge clk);
    n++;
    if (wd) exp_d = data & 255;
    else if ((n % DIV) == 0 && exp_d > 0) exp_d--;
    if (ws) exp_s = data & 255;
    else if ((n % DIV) == 0 && exp_s > 0) exp_s--;
    @(negedge clk);
    dly_wr = 1'b0;
    snd_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    exp_d = 0;
    exp_s = 0;
  endtask

  task automatic idle(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      cyc(1'b0, 1'b0, 0);
      check_all(tag);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 delay after reset", int'(dly_val), 0);
    check("R1 sound after reset", int'(snd_val), 0);
    check("R1 buzzer after reset", int'(buzz_on), 0);
    idle(3 * DIV, "R3 idle at zero");

    // R4 load delay, then count down to zero and hold (R2, R3)
    cyc(1'b1, 1'b0, 5);
    check("R4 delay load", int'(dly_val), 5);
    check("R6 sound untouched", int'(snd_val), 0);
    idle(8 * DIV, "R2 countdown");
    check("R3 delay held at zero", int'(dly_val), 0);

    // sweep write phase over the full divider period
    for (int ph = 0; ph < DIV; ph++) begin
      idle(ph, "R2 phase wait");
      cyc(1'b0, 1'b1, ph + 1);
      check("R4 sound load", int'(snd_val), ph + 1);
      check("R7 buzzer on after load", int'(buzz_on), 1);
      cyc(1'b1, 1'b0, 2 * ph + 3);
      check("R6 delay load keeps sound", int'(dly_val), 2 * ph + 3);
      idle((ph + 3) * DIV, "R6 sweep");
      check("R7 buzzer off at zero", int'(buzz_on), 0);
    end

    // R5 write on a tick edge: align so the next edge is a tick
    while (((n + 1) % DIV) != 0) cyc(1'b0, 1'b0, 0);
    cyc(1'b1, 1'b1, 9);
    check("R5 delay load on tick", int'(dly_val), 9);
    check("R5 sound load on tick", int'(snd_val), 9);
    check_all("R6 both strobes");

    // R3 load 0 to sound turns buzzer off next cycle
    cyc(1'b0, 1'b1, 0);
    check("R7 buzzer off after zero load", int'(buzz_on), 0);
    check("R4 sound zero load", int'(snd_val), 0);
    idle(2 * DIV, "R3 sound at zero");

    // maximum value load and a few ticks
    cyc(1'b0, 1'b1, 255);
    check("R4 sound max load", int'(snd_val), 255);
    idle(4 * DIV, "R2 from max");

    // R1 mid-run reset at an odd phase restarts the divider
    idle(3, "R2 pre-reset");
    do_reset();
    check("R1 delay cleared mid-run", int'(dly_val), 0);
    check("R1 sound cleared mid-run", int'(snd_val), 0);
    check("R1 buzzer cleared mid-run", int'(buzz_on), 0);
    cyc(1'b1, 1'b1, 2);
    idle(DIV - 2, "R1 before first tick");
    check("R1 no early tick", int'(dly_val), 2);
    idle(1, "R1 first tick");
    check("R1 first tick at DIV", int'(dly_val), 1);
    idle(2 * DIV, "R3 after restart");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule